// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block manages a bank of general-purpose pins, 32 by default. Each pin is either driven by the bank or sampled from outside, depending on its direction bit. Sampled pins pass through a two-flop synchroniser and an optional per-pin inversion before they land in a shared stored-value register. Driven pins take their level from that same register, which software updates with a full write or with atomic set and clear strobes that only touch driven pins.

Pins are arranged in groups of 8, and each group has one interrupt line. When a sampled pin's stored value goes from 0 to 1, its cause bit is latched. If that pin is also enabled in the mask, its group's interrupt line rises. A mode bit in a control word decides how the line falls again. In edge mode, software writes the cause register. In level mode, the line falls once every stored value in the group is back to 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction, stored value, polarity, cause and mask registers all read 0, edge mode is selected, and every group interrupt line is low.
- R2: A write to the value register (offset 1) changes only pins whose direction bit (offset 0) is 1. Pins with direction 0 keep their sampled value. `pin_out` shows the stored value and `pin_oe` shows the direction register.
- R3: A write to the set strobe (offset 2) ORs (data AND direction) into the stored value. A write to the clear strobe (offset 3) clears (data AND direction). Both offsets read as 0.
- R4: A sampled pin reaches the stored value through two synchroniser flops, so the stored value changes at the third rising clock edge after the pin changes. When a pin's polarity bit (offset 4) is 1, its input is inverted before it is stored.
- R5: A 0-to-1 change in the stored value of a pin with direction 0 sets that pin's cause bit (offset 5). Register writes to driven pins never set cause bits. A software write to offset 5 replaces the cause register with the written data.
- R6: A cause-setting rise on pin n whose mask bit is 1 raises `grp_irq[n/8]`. A rise on a pin whose mask bit is 0 sets the cause bit only.
- R7: Offsets 6 and 7 both read and write a single shared mask register.
- R8: In edge mode (control bit 10 = 0), a group interrupt stays high after its pins fall. A write to the cause register whose 8-bit field for that group is all zero lowers that group's interrupt.
- R9: In level mode (control bit 10 = 1), a group interrupt falls when every stored value in its group is 0. A cause write does not lower it.
- R10: The control register (offset 8) reads 0x11FF0000 OR (mode bit shifted left by 10). Only bit 10 of a write to it is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at `reg_addr` (combinational) |
| pin_in | input | PIN_W | Raw pin inputs |
| pin_out | output | PIN_W | Stored pin values |
| pin_oe | output | PIN_W | Output enables (direction register) |
| grp_irq | output | PIN_W/GRP_W | One interrupt line per group of pins |

## Verification
The bench targets the following corner cases:

- **Full writes to a mixed-direction value register.** A design that lets the write reach sampled pins shows the written data instead of the pin levels.
- **Set and clear strobes with data on input pins.** A design that forgets to qualify the strobes by direction corrupts those pins.
- **Synchroniser latency.** Reading the stored value one cycle before and at the expected edge catches a missing or extra stage.
- **Polarity inversion.** Turning it on while a pin is low must itself count as a rise.
- **Register writes to driven pins.** A design that sets cause bits from these writes raises spurious causes.
- **Edge versus level clearing.** The bench drops a pin in edge mode and expects the line to stay high. It writes the cause register in level mode and expects no drop. It releases only one of two high pins in a level-mode group, so a design that clears on any single fall instead of on the whole group releases the line early.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 4;
   localparam int MODE_BIT = 10;

   localparam logic [DATA_W-1:0] CTRL_FIXED = 32'h11FF_0000;

   localparam logic [ADDR_W-1:0] OFS_DIR    = 4'd0;
   localparam logic [ADDR_W-1:0] OFS_VAL    = 4'd1;
   localparam logic [ADDR_W-1:0] OFS_SET    = 4'd2;
   localparam logic [ADDR_W-1:0] OFS_CLR    = 4'd3;
   localparam logic [ADDR_W-1:0] OFS_POL    = 4'd4;
   localparam logic [ADDR_W-1:0] OFS_CAUSE  = 4'd5;
   localparam logic [ADDR_W-1:0] OFS_MASK_A = 4'd6;
   localparam logic [ADDR_W-1:0] OFS_MASK_B = 4'd7;
   localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd8;

   typedef struct packed {
      logic dir;
      logic val;
      logic set;
      logic clr;
      logic pol;
      logic cause;
      logic mask;
      logic ctrl;
   } wr_strb_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 2) begin : g_pair
         logic [WIDTH-1:0] meta_q;
         logic [WIDTH-1:0] stable_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q   <= '0;
               stable_q <= '0;
            end else begin
               meta_q   <= d;
               stable_q <= meta_q;
            end
         end

         assign q = stable_q;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int PIN_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  gpio_bank_pkg::wr_strb_t strb,
   input  logic [PIN_W-1:0]        wdata,
   input  logic                    mode_d,
   input  logic [PIN_W-1:0]        smp,
   output logic [PIN_W-1:0]        dir_q,
   output logic [PIN_W-1:0]        pol_q,
   output logic [PIN_W-1:0]        mask_q,
   output logic                    mode_q,
   output logic [PIN_W-1:0]        value_q,
   output logic [PIN_W-1:0]        value_nxt,
   output logic [PIN_W-1:0]        rise
);

   logic [PIN_W-1:0] drv_upd;
   logic [PIN_W-1:0] in_lvl;

   // sampled level after optional inversion
   assign in_lvl = smp ^ pol_q;

   // software update of driven pins; strobes are mutually exclusive by offset
   always_comb begin
      drv_upd = value_q;
      if (strb.val)      drv_upd = wdata;
      else if (strb.set) drv_upd = value_q | wdata;
      else if (strb.clr) drv_upd = value_q & ~wdata;
   end

   assign value_nxt = (drv_upd & dir_q) | (in_lvl & ~dir_q);

   // only sampled pins can report a rise
   assign rise = ~dir_q & in_lvl & ~value_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         pol_q   <= '0;
         mask_q  <= '0;
         mode_q  <= 1'b0;
         value_q <= '0;
      end else begin
         if (strb.dir)  dir_q  <= wdata;
         if (strb.pol)  pol_q  <= wdata;
         if (strb.mask) mask_q <= wdata;
         if (strb.ctrl) mode_q <= mode_d;
         value_q <= value_nxt;
      end
   end

endmodule

// File: rtl/gpio_bank_intr.sv
module gpio_bank_intr #(
   parameter int PIN_W = 32,
   parameter int GRP_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cause_wr,
   input  logic [PIN_W-1:0]         wdata,
   input  logic [PIN_W-1:0]         rise,
   input  logic [PIN_W-1:0]         mask,
   input  logic                     mode,
   input  logic [PIN_W-1:0]         value_nxt,
   output logic [PIN_W-1:0]         cause_q,
   output logic [PIN_W/GRP_W-1:0]   irq
);

   localparam int N_GRP = PIN_W / GRP_W;

   // a write replaces the cause contents; a same-cycle rise still lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_wr ? wdata : cause_q) | rise;
   end

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         localparam int LO = g * GRP_W;
         logic hit;
         logic clr_lvl;
         logic clr_edge;
         logic irq_r;

         assign hit      = |(rise[LO +: GRP_W] & mask[LO +: GRP_W]);
         assign clr_lvl  = mode & ~|value_nxt[LO +: GRP_W];
         assign clr_edge = ~mode & cause_wr & ~|wdata[LO +: GRP_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     irq_r <= 1'b0;
            else if (hit)                   irq_r <= 1'b1;
            else if (clr_lvl || clr_edge)   irq_r <= 1'b0;
         end

         assign irq[g] = irq_r;
      end
   endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int PIN_W       = 32,
   parameter int GRP_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic [PIN_W-1:0]         pin_in,
   output logic [PIN_W-1:0]         pin_out,
   output logic [PIN_W-1:0]         pin_oe,
   output logic [PIN_W/GRP_W-1:0]   grp_irq
);

   generate
      if (PIN_W > DATA_W || PIN_W < 1) begin : g_bad_pins
         $error("gpio_bank: PIN_W must lie in 1..%0d", DATA_W);
      end
      if (GRP_W < 1 || (PIN_W % GRP_W) != 0) begin : g_bad_grp
         $error("gpio_bank: PIN_W must be a multiple of GRP_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_bank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   wr_strb_t         strb;
   logic [PIN_W-1:0] wdata_p;
   logic [PIN_W-1:0] smp;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] pol_q;
   logic [PIN_W-1:0] mask_q;
   logic             mode_q;
   logic [PIN_W-1:0] value_q;
   logic [PIN_W-1:0] value_nxt;
   logic [PIN_W-1:0] rise;
   logic [PIN_W-1:0] cause_q;

   assign wdata_p = reg_wdata[PIN_W-1:0];

   always_comb begin
      strb = '0;
      if (reg_wr) begin
         case (reg_addr)
            OFS_DIR:                strb.dir   = 1'b1;
            OFS_VAL:                strb.val   = 1'b1;
            OFS_SET:                strb.set   = 1'b1;
            OFS_CLR:                strb.clr   = 1'b1;
            OFS_POL:                strb.pol   = 1'b1;
            OFS_CAUSE:              strb.cause = 1'b1;
            OFS_MASK_A, OFS_MASK_B: strb.mask  = 1'b1;
            OFS_CTRL:               strb.ctrl  = 1'b1;
            default: ;
         endcase
      end
   end

   gpio_bank_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp)
   );

   gpio_bank_regs #(
      .PIN_W (PIN_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb      (strb),
      .wdata     (wdata_p),
      .mode_d    (reg_wdata[MODE_BIT]),
      .smp       (smp),
      .dir_q     (dir_q),
      .pol_q     (pol_q),
      .mask_q    (mask_q),
      .mode_q    (mode_q),
      .value_q   (value_q),
      .value_nxt (value_nxt),
      .rise      (rise)
   );

   gpio_bank_intr #(
      .PIN_W (PIN_W),
      .GRP_W (GRP_W)
   ) u_intr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cause_wr  (strb.cause),
      .wdata     (wdata_p),
      .rise      (rise),
      .mask      (mask_q),
      .mode      (mode_q),
      .value_nxt (value_nxt),
      .cause_q   (cause_q),
      .irq       (grp_irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_DIR:                reg_rdata[PIN_W-1:0] = dir_q;
         OFS_VAL:                reg_rdata[PIN_W-1:0] = value_q;
         OFS_POL:                reg_rdata[PIN_W-1:0] = pol_q;
         OFS_CAUSE:              reg_rdata[PIN_W-1:0] = cause_q;
         OFS_MASK_A, OFS_MASK_B: reg_rdata[PIN_W-1:0] = mask_q;
         OFS_CTRL: begin
            reg_rdata           = CTRL_FIXED;
            reg_rdata[MODE_BIT] = mode_q;
         end
         default: ;
      endcase
   end

   assign pin_out = value_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int PIN_W = 32,
   parameter int GRP_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]      reg_wdata,
   input logic [DATA_W-1:0]      reg_rdata,
   input logic [PIN_W-1:0]       dir,
   input logic [PIN_W-1:0]       value,
   input logic [PIN_W-1:0]       cause,
   input logic [PIN_W-1:0]       mask,
   input logic                   mode,
   input logic [PIN_W/GRP_W-1:0] grp_irq
);

   localparam int N_GRP = PIN_W / GRP_W;

   // R2
   value_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_VAL) |=>
         ((value & $past(dir)) == ($past(reg_wdata[PIN_W-1:0]) & $past(dir))));

   // R3
   set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_SET) |=>
         ((value & $past(dir)) ==
          (($past(value) | $past(reg_wdata[PIN_W-1:0])) & $past(dir))));

   // R3
   clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_CLR) |=>
         ((value & $past(dir)) ==
          (($past(value) & ~$past(reg_wdata[PIN_W-1:0])) & $past(dir))));

   // R3
   alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_SET || reg_addr == OFS_CLR) |-> (reg_rdata == '0));

   // R7
   mask_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_MASK_B) |-> (reg_rdata[PIN_W-1:0] == mask));

   // R10
   ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_CTRL) |->
         (reg_rdata[MODE_BIT] == mode &&
          (reg_rdata & ~(32'h1 << MODE_BIT)) == CTRL_FIXED));

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
         localparam int LO = g * GRP_W;

         // R6
         irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(grp_irq[g]) && $stable(mask)) |->
               (|(cause[LO +: GRP_W] & mask[LO +: GRP_W])));

         // R9
         level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode |=> (!grp_irq[g] || |value[LO +: GRP_W]));

         // R8
         edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode && reg_wr && reg_addr == OFS_CAUSE && reg_wdata[LO +: GRP_W] == '0) |=>
               (!grp_irq[g] || |cause[LO +: GRP_W]));
      end
   endgenerate

endmodule

bind gpio_bank gpio_bank_chk #(
   .PIN_W (PIN_W),
   .GRP_W (GRP_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .dir       (dir_q),
   .value     (value_q),
   .cause     (cause_q),
   .mask      (mask_q),
   .mode      (mode_q),
   .grp_irq   (grp_irq)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

   localparam int PIN_W = 32;
   localparam int N_GRP = 4;

   localparam logic [3:0] A_DIR = 4'd0, A_VAL = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                          A_POL = 4'd4, A_CAUSE = 4'd5, A_MSKA = 4'd6, A_MSKB = 4'd7,
                          A_CTRL = 4'd8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [3:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [PIN_W-1:0] pin_in = '0;
   logic [PIN_W-1:0] pin_out;
   logic [PIN_W-1:0] pin_oe;
   logic [N_GRP-1:0] grp_irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gpio_bank i_gpio_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .grp_irq   (grp_irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %08h exp %08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic drive_pins(input logic [PIN_W-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_DIR, d);   check("R1 dir", d, 32'h0);
      rd(A_VAL, d);   check("R1 value", d, 32'h0);
      rd(A_POL, d);   check("R1 pol", d, 32'h0);
      rd(A_CAUSE, d); check("R1 cause", d, 32'h0);
      rd(A_MSKA, d);  check("R1 mask", d, 32'h0);
      rd(A_CTRL, d);  check("R1 ctrl edge mode", d, 32'h11FF_0000);
      check("R1 irq", {28'h0, grp_irq}, 32'h0);
   endtask

   task automatic t_value_write();
      logic [31:0] d;
      wr(A_DIR, 32'h0000_FFFF);
      drive_pins(32'h00FF_0000);
      wr(A_VAL, 32'hFFFF_1234);
      rd(A_VAL, d);
      check("R2 value keeps inputs", d, 32'h00FF_1234);
      check("R2 pin_out", pin_out, 32'h00FF_1234);
      check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
      rd(A_CAUSE, d);
      check("R5 writes set no cause", d, 32'h00FF_0000);
      drive_pins(32'h0);
      wr(A_CAUSE, 32'h0);
   endtask

   task automatic t_set_clr();
      logic [31:0] d;
      wr(A_VAL, 32'h0);
      wr(A_SET, 32'hFFFF_00FF);
      rd(A_VAL, d); check("R3 set alias", d, 32'h0000_00FF);
      wr(A_CLR, 32'hFFFF_000F);
      rd(A_VAL, d); check("R3 clr alias", d, 32'h0000_00F0);
      rd(A_SET, d); check("R3 set reads 0", d, 32'h0);
      rd(A_CLR, d); check("R3 clr reads 0", d, 32'h0);
      rd(A_CAUSE, d); check("R5 strobes set no cause", d, 32'h0);
   endtask

   task automatic t_polarity();
      logic [31:0] d;
      wr(A_DIR, 32'h0);
      wr(A_POL, 32'h0000_FF00);
      @(negedge clk);
      rd(A_VAL, d);   check("R4 inverted input", d, 32'h0000_FF00);
      rd(A_CAUSE, d); check("R5 polarity rise cause", d, 32'h0000_FF00);
      @(negedge clk);
      pin_in = 32'h0000_0100;
      repeat (2) @(negedge clk);
      rd(A_VAL, d);   check("R4 sync not yet", d, 32'h0000_FF00);
      @(negedge clk);
      rd(A_VAL, d);   check("R4 sync third edge", d, 32'h0000_FE00);
      drive_pins(32'h0);
      wr(A_POL, 32'h0);
      repeat (2) @(negedge clk);
      wr(A_CAUSE, 32'h0);
      rd(A_VAL, d);   check("R4 cleanup value", d, 32'h0);
   endtask

   task automatic t_mask_alias();
      logic [31:0] d;
      wr(A_MSKB, 32'h0000_0200);
      rd(A_MSKA, d); check("R7 mask alias A", d, 32'h0000_0200);
      rd(A_MSKB, d); check("R7 mask alias B", d, 32'h0000_0200);
   endtask

   task automatic t_edge_irq();
      logic [31:0] d;
      drive_pins(32'h0000_0200);
      check("R6 masked rise irq", {28'h0, grp_irq}, 32'h2);
      rd(A_CAUSE, d); check("R5 cause bit 9", d, 32'h0000_0200);
      drive_pins(32'h0);
      check("R8 edge irq holds after fall", {28'h0, grp_irq}, 32'h2);
      wr(A_CAUSE, 32'hFFFF_00FF);
      check("R8 cause write clears group", {28'h0, grp_irq}, 32'h0);
      rd(A_CAUSE, d); check("R5 cause replaced", d, 32'hFFFF_00FF);
      wr(A_CAUSE, 32'h0);
   endtask

   task automatic t_unmasked();
      logic [31:0] d;
      drive_pins(32'h0010_0000);
      rd(A_CAUSE, d); check("R6 unmasked cause", d, 32'h0010_0000);
      check("R6 unmasked no irq", {28'h0, grp_irq}, 32'h0);
      drive_pins(32'h0);
      wr(A_CAUSE, 32'h0);
   endtask

   task automatic t_level_irq();
      logic [31:0] d;
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, d); check("R10 ctrl level", d, 32'h11FF_0400);
      wr(A_MSKA, 32'h0300_0000);
      drive_pins(32'h0300_0000);
      check("R9 level irq up", {28'h0, grp_irq}, 32'h8);
      wr(A_CAUSE, 32'h0);
      check("R9 cause write keeps irq", {28'h0, grp_irq}, 32'h8);
      drive_pins(32'h0100_0000);
      check("R9 one pin still high", {28'h0, grp_irq}, 32'h8);
      drive_pins(32'h0);
      check("R9 group all zero drops", {28'h0, grp_irq}, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_value_write();
      t_set_clr();
      t_polarity();
      t_mask_alias();
      t_edge_irq();
      t_unmasked();
      t_level_irq();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule